// File: doc/BRIEF.md
# Control endpoint handshake responder

This block is the endpoint-control slice of a low-speed USB serial interface engine. The packet layer presents it with decoded tokens (SETUP, IN, OUT), the received byte count, a CRC-good flag and the data toggle that arrived with the packet. The block answers each token with a handshake choice. That choice depends on a 4-bit mode code, which firmware loads and which the hardware advances by itself when a control transfer stage completes.

A count register holds the last stored byte count, a data-valid bit and a data-toggle bit. Firmware and the engine can both write the mode and count registers. An interlock resolves this: once the engine updates either register, the lock holds and firmware writes to them are dropped until firmware acknowledges what it has seen. A device address register can be written by firmware at any time. A bus reset clears it.

Top module: `usb_ctl_ep_resp`

## Requirements
- R1: With mode 0000 (off), every token gives no handshake and leaves mode, count, valid, toggle and lock unchanged.
- R2: Mode 0001 answers IN and OUT with NAK. Mode 1000 answers OUT with NAK and gives no handshake for IN. Neither changes any register.
- R3: Mode 0011 answers IN and OUT with STALL. Any code not named in R1 to R7 gives no handshake to IN or OUT.
- R4: In any mode other than 0000, a SETUP with a count above 10 is dropped: no handshake and no register change. A SETUP with a count of 10 or less stores the count, sets valid to the CRC flag, stores the received toggle and sets the lock. If the CRC is good it is answered with ACK and the mode becomes 0001, even from STALL. If the CRC is bad there is no handshake.
- R5: Mode 0010 ACKs a zero-length OUT and moves to 0001. It STALLs an OUT with data and also STALLs IN. Mode 0110 ACKs IN and moves to 0001, and STALLs OUT. Each move sets the lock.
- R6: Mode 1011 ACKs OUT and sets the lock. If the received toggle differs from the stored toggle, the block stores the count, sets valid to 1 and stores the toggle. If the toggle matches, valid is cleared and the count and toggle are kept. IN in mode 1011 is ACKed and the mode moves to 0001.
- R7: Mode 1111 ACKs IN and changes nothing. It ACKs a zero-length OUT and moves to 0001 with the lock set. It STALLs an OUT with data.
- R8: An OUT with a bad CRC gives no handshake and no register change, in every mode.
- R9: Firmware writes with fw_sel_i 0 (mode, data bits [3:0]) or 1 (count in [3:0], valid in bit 6, toggle in bit 7) take effect only when the lock is clear and the engine is not updating in that same cycle. fw_ack_i clears the lock unless the engine sets it in the same cycle.
- R10: A firmware write with fw_sel_i 2 loads the address from data bits [6:0]. bus_reset_i clears the address and takes priority over a write in the same cycle.
- R11: Tokens are encoded SETUP=0, IN=1, OUT=2, with 3 ignored. Handshakes are encoded none=0, ACK=1, NAK=2, STALL=3. hs_o shows the answer in the cycle after the token and is none in every other cycle. After reset all registers are zero and hs_o is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | USB bus reset detected |
| tok_valid_i | input | 1 | Decoded token present this cycle |
| tok_kind_i | input | 2 | Token kind |
| rx_count_i | input | CNT_W | Received data byte count |
| rx_crc_ok_i | input | 1 | Data packet CRC good |
| rx_toggle_i | input | 1 | Received data toggle |
| fw_wr_i | input | 1 | Firmware write strobe |
| fw_sel_i | input | 2 | Firmware register select |
| fw_wdata_i | input | 8 | Firmware write data |
| fw_ack_i | input | 1 | Firmware acknowledge, clears lock |
| hs_o | output | 2 | Handshake answer |
| mode_o | output | 4 | Current mode code |
| cnt_o | output | CNT_W | Stored byte count |
| dval_o | output | 1 | Data-valid bit |
| tog_o | output | 1 | Stored data toggle |
| addr_o | output | 7 | Device address |
| lock_o | output | 1 | Interlock active |

## Verification
Every result lands on the first rising edge after its stimulus. hs_o is registered, and the mode, count, valid, toggle, address and lock registers update on that same edge. The bench drives each stimulus at a falling edge and steps a bench model of all registers in the same cycle. It compares every output one time unit after the next rising edge, so the handshake and the register state are checked together against that model. Same-cycle conflicts between the engine, firmware writes, acknowledges and bus reset are driven on purpose, so the priority order is checked on the very edge where it matters.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic [1:0] {TOK_SETUP = 2'd0, TOK_IN = 2'd1, TOK_OUT = 2'd2, TOK_RSVD = 2'd3} tok_e;
  typedef enum logic [1:0] {HS_NONE = 2'd0, HS_ACK = 2'd1, HS_NAK = 2'd2, HS_STALL = 2'd3} hs_e;

  localparam logic [3:0] M_OFF      = 4'b0000;
  localparam logic [3:0] M_NAK_IO   = 4'b0001;
  localparam logic [3:0] M_STAT_OUT = 4'b0010;
  localparam logic [3:0] M_STALL_IO = 4'b0011;
  localparam logic [3:0] M_STAT_IN  = 4'b0110;
  localparam logic [3:0] M_NAK_OUT  = 4'b1000;
  localparam logic [3:0] M_DATA_OUT = 4'b1011;
  localparam logic [3:0] M_DATA_IN  = 4'b1111;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;
endpackage

// File: rtl/ep_resp_decide.sv
module ep_resp_decide
  import usb_ep_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SETUP_MAX = 10
) (
  input  logic             tok_valid_i,
  input  logic [1:0]       tok_kind_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             rx_crc_ok_i,
  input  logic             rx_toggle_i,
  input  logic [3:0]       mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tog_i,
  output hs_e              hs_o,
  output logic             set_mode_o,
  output logic [3:0]       mode_nxt_o,
  output logic             set_cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             dval_nxt_o,
  output logic             tog_nxt_o
);
  localparam logic [CNT_W-1:0] SETUP_LIM = CNT_W'(SETUP_MAX);

  tok_e kind;
  logic zero_len;
  assign kind     = tok_e'(tok_kind_i);
  assign zero_len = (rx_count_i == '0);

  // status-stage completion: hand control back with NAK on both directions
  always_comb begin
    hs_o       = HS_NONE;
    set_mode_o = 1'b0;
    mode_nxt_o = M_NAK_IO;
    set_cnt_o  = 1'b0;
    cnt_nxt_o  = cnt_i;
    dval_nxt_o = 1'b0;
    tog_nxt_o  = tog_i;
    if (tok_valid_i && mode_i != M_OFF) begin
      case (kind)
        TOK_SETUP: if (rx_count_i <= SETUP_LIM) begin
          set_cnt_o  = 1'b1;
          cnt_nxt_o  = rx_count_i;
          dval_nxt_o = rx_crc_ok_i;
          tog_nxt_o  = rx_toggle_i;
          if (rx_crc_ok_i) begin
            hs_o       = HS_ACK;
            set_mode_o = 1'b1;
          end
        end
        TOK_IN: begin
          case (mode_i)
            M_NAK_IO:                 hs_o = HS_NAK;
            M_STALL_IO, M_STAT_OUT:   hs_o = HS_STALL;
            M_STAT_IN, M_DATA_OUT: begin
              hs_o       = HS_ACK;
              set_mode_o = 1'b1;
            end
            M_DATA_IN:                hs_o = HS_ACK;
            default:                  hs_o = HS_NONE;
          endcase
        end
        TOK_OUT: if (rx_crc_ok_i) begin
          case (mode_i)
            M_NAK_IO, M_NAK_OUT:      hs_o = HS_NAK;
            M_STALL_IO, M_STAT_IN:    hs_o = HS_STALL;
            M_STAT_OUT, M_DATA_IN: begin
              if (zero_len) begin
                hs_o       = HS_ACK;
                set_mode_o = 1'b1;
              end else begin
                hs_o = HS_STALL;
              end
            end
            M_DATA_OUT: begin
              hs_o      = HS_ACK;
              set_cnt_o = 1'b1;
              if (rx_toggle_i != tog_i) begin
                cnt_nxt_o  = rx_count_i;
                dval_nxt_o = 1'b1;
                tog_nxt_o  = rx_toggle_i;
              end
            end
            default:                  hs_o = HS_NONE;
          endcase
        end
        default: hs_o = HS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ep_resp_regs.sv
module ep_resp_regs
  import usb_ep_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 7,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic              set_mode_i,
  input  logic [3:0]        mode_nxt_i,
  input  logic              set_cnt_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  input  logic              dval_nxt_i,
  input  logic              tog_nxt_i,
  input  logic              fw_wr_i,
  input  logic [1:0]        fw_sel_i,
  input  logic [DW-1:0]     fw_wdata_i,
  input  logic              fw_ack_i,
  output logic [3:0]        mode_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dval_o,
  output logic              tog_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              lock_o
);
  localparam int DVAL_BIT = 6;
  localparam int TOG_BIT  = 7;

  logic eng_busy, fw_ok;
  assign eng_busy = set_mode_i | set_cnt_i;
  assign fw_ok    = fw_wr_i & ~lock_o & ~eng_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= M_OFF;
      cnt_o  <= '0;
      dval_o <= 1'b0;
      tog_o  <= 1'b0;
      lock_o <= 1'b0;
    end else begin
      if (set_mode_i)                          mode_o <= mode_nxt_i;
      else if (fw_ok && fw_sel_i == SEL_MODE)  mode_o <= fw_wdata_i[3:0];

      if (set_cnt_i) begin
        cnt_o  <= cnt_nxt_i;
        dval_o <= dval_nxt_i;
        tog_o  <= tog_nxt_i;
      end else if (fw_ok && fw_sel_i == SEL_CNT) begin
        cnt_o  <= fw_wdata_i[CNT_W-1:0];
        dval_o <= fw_wdata_i[DVAL_BIT];
        tog_o  <= fw_wdata_i[TOG_BIT];
      end

      if (eng_busy)      lock_o <= 1'b1;
      else if (fw_ack_i) lock_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   addr_o <= '0;
    else if (bus_reset_i)                          addr_o <= '0;
    else if (fw_wr_i && fw_sel_i == SEL_ADDR)      addr_o <= fw_wdata_i[ADDR_W-1:0];
  end
endmodule

// File: rtl/usb_ctl_ep_resp.sv
module usb_ctl_ep_resp
  import usb_ep_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SETUP_MAX = 10,
  parameter int ADDR_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic              tok_valid_i,
  input  logic [1:0]        tok_kind_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              rx_crc_ok_i,
  input  logic              rx_toggle_i,
  input  logic              fw_wr_i,
  input  logic [1:0]        fw_sel_i,
  input  logic [7:0]        fw_wdata_i,
  input  logic              fw_ack_i,
  output logic [1:0]        hs_o,
  output logic [3:0]        mode_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dval_o,
  output logic              tog_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              lock_o
);
  hs_e              hs_d;
  logic             set_mode, set_cnt, dval_nxt, tog_nxt;
  logic [3:0]       mode_nxt;
  logic [CNT_W-1:0] cnt_nxt;

  ep_resp_decide #(.CNT_W(CNT_W), .SETUP_MAX(SETUP_MAX)) u_decide (
    .tok_valid_i (tok_valid_i),
    .tok_kind_i  (tok_kind_i),
    .rx_count_i  (rx_count_i),
    .rx_crc_ok_i (rx_crc_ok_i),
    .rx_toggle_i (rx_toggle_i),
    .mode_i      (mode_o),
    .cnt_i       (cnt_o),
    .tog_i       (tog_o),
    .hs_o        (hs_d),
    .set_mode_o  (set_mode),
    .mode_nxt_o  (mode_nxt),
    .set_cnt_o   (set_cnt),
    .cnt_nxt_o   (cnt_nxt),
    .dval_nxt_o  (dval_nxt),
    .tog_nxt_o   (tog_nxt)
  );

  ep_resp_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DW(8)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .set_mode_i  (set_mode),
    .mode_nxt_i  (mode_nxt),
    .set_cnt_i   (set_cnt),
    .cnt_nxt_i   (cnt_nxt),
    .dval_nxt_i  (dval_nxt),
    .tog_nxt_i   (tog_nxt),
    .fw_wr_i     (fw_wr_i),
    .fw_sel_i    (fw_sel_i),
    .fw_wdata_i  (fw_wdata_i),
    .fw_ack_i    (fw_ack_i),
    .mode_o      (mode_o),
    .cnt_o       (cnt_o),
    .dval_o      (dval_o),
    .tog_o       (tog_o),
    .addr_o      (addr_o),
    .lock_o      (lock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hs_o <= HS_NONE;
    else         hs_o <= hs_d;
  end
endmodule

// File: rtl/usb_ctl_ep_resp_chk.sv
module usb_ctl_ep_resp_chk #(
  parameter int CNT_W     = 4,
  parameter int SETUP_MAX = 10,
  parameter int ADDR_W    = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_reset_i,
  input logic              tok_valid_i,
  input logic [1:0]        tok_kind_i,
  input logic [CNT_W-1:0]  rx_count_i,
  input logic              rx_crc_ok_i,
  input logic              fw_wr_i,
  input logic [1:0]        fw_sel_i,
  input logic [1:0]        hs_o,
  input logic [3:0]        mode_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              lock_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(SETUP_MAX);

  assert_hs_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_valid_i |=> hs_o == 2'd0);

  assert_off_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && mode_o == 4'b0000) |=> (hs_o == 2'd0 && $stable(lock_o)));

  assert_stall_both_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && mode_o == 4'b0011 && tok_kind_i == 2'd1) |=> hs_o == 2'd3);

  assert_setup_long_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && mode_o != 4'b0000 && tok_kind_i == 2'd0 && rx_count_i > LIM && !fw_wr_i)
      |=> (hs_o == 2'd0 && $stable(mode_o) && $stable(cnt_o)));

  assert_bad_crc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && tok_kind_i == 2'd2 && !rx_crc_ok_i) |=> hs_o == 2'd0);

  assert_lock_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !tok_valid_i) |=> ($stable(mode_o) && $stable(cnt_o)));

  assert_bus_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> addr_o == '0);
endmodule

bind usb_ctl_ep_resp usb_ctl_ep_resp_chk #(.CNT_W(CNT_W), .SETUP_MAX(SETUP_MAX), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_reset_i (bus_reset_i),
  .tok_valid_i (tok_valid_i),
  .tok_kind_i  (tok_kind_i),
  .rx_count_i  (rx_count_i),
  .rx_crc_ok_i (rx_crc_ok_i),
  .fw_wr_i     (fw_wr_i),
  .fw_sel_i    (fw_sel_i),
  .hs_o        (hs_o),
  .mode_o      (mode_o),
  .cnt_o       (cnt_o),
  .addr_o      (addr_o),
  .lock_o      (lock_o)
);

// File: tb/usb_ctl_ep_resp_tb.sv
`timescale 1ns/1ps
module usb_ctl_ep_resp_tb;
  localparam int CNT_W = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_reset_i = 0, tok_valid_i = 0, rx_crc_ok_i = 0, rx_toggle_i = 0;
  logic fw_wr_i = 0, fw_ack_i = 0;
  logic [1:0] tok_kind_i = 0, fw_sel_i = 0;
  logic [CNT_W-1:0] rx_count_i = 0;
  logic [7:0] fw_wdata_i = 0;
  logic [1:0] hs_o;
  logic [3:0] mode_o;
  logic [CNT_W-1:0] cnt_o;
  logic dval_o, tog_o, lock_o;
  logic [6:0] addr_o;

  int checks = 0, errors = 0;

  // bench model
  logic [1:0] e_hs = 0;
  logic [3:0] e_mode = 0;
  logic [CNT_W-1:0] e_cnt = 0;
  logic e_dval = 0, e_tog = 0, e_lock = 0;
  logic [6:0] e_addr = 0;

  always #5 clk_i = ~clk_i;

  usb_ctl_ep_resp u_dut (.*);

  task automatic compare(input string tag);
    checks++;
    if ({hs_o, mode_o, cnt_o, dval_o, tog_o, addr_o, lock_o} !==
        {e_hs, e_mode, e_cnt, e_dval, e_tog, e_addr, e_lock}) begin
      errors++;
      $display("FAIL %s: got hs=%0d mode=%b cnt=%0d dval=%0d tog=%0d addr=%0h lock=%0d, exp hs=%0d mode=%b cnt=%0d dval=%0d tog=%0d addr=%0h lock=%0d",
        tag, hs_o, mode_o, cnt_o, dval_o, tog_o, addr_o, lock_o,
        e_hs, e_mode, e_cnt, e_dval, e_tog, e_addr, e_lock);
    end
  endtask

  task automatic model(input logic tv, input logic [1:0] k, input logic [CNT_W-1:0] n,
                       input logic crc, input logic tg, input logic wr, input logic [1:0] sel,
                       input logic [7:0] wd, input logic ack, input logic br);
    logic [1:0] hs = 0;
    logic upd_m = 0, upd_c = 0;
    logic [3:0] nm = 4'b0001;
    logic [CNT_W-1:0] nc = e_cnt;
    logic nd = 0, nt = e_tog;
    if (tv && e_mode != 4'b0000) begin
      if (k == 2'd0) begin
        if (n <= 10) begin
          upd_c = 1; nc = n; nd = crc; nt = tg;
          if (crc) begin hs = 1; upd_m = 1; end
        end
      end else if (k == 2'd1) begin
        case (e_mode)
          4'b0001: hs = 2;
          4'b0011, 4'b0010: hs = 3;
          4'b0110, 4'b1011: begin hs = 1; upd_m = 1; end
          4'b1111: hs = 1;
          default: hs = 0;
        endcase
      end else if (k == 2'd2 && crc) begin
        case (e_mode)
          4'b0001, 4'b1000: hs = 2;
          4'b0011, 4'b0110: hs = 3;
          4'b0010, 4'b1111: if (n == 0) begin hs = 1; upd_m = 1; end else hs = 3;
          4'b1011: begin
            hs = 1; upd_c = 1;
            if (tg != e_tog) begin nc = n; nd = 1; nt = tg; end
          end
          default: hs = 0;
        endcase
      end
    end
    e_hs = hs;
    if (br) e_addr = 0;
    else if (wr && sel == 2) e_addr = wd[6:0];
    if (upd_m) e_mode = nm;
    else if (wr && sel == 0 && !e_lock && !upd_c) e_mode = wd[3:0];
    if (upd_c) begin e_cnt = nc; e_dval = nd; e_tog = nt; end
    else if (wr && sel == 1 && !e_lock && !upd_m) begin e_cnt = wd[3:0]; e_dval = wd[6]; e_tog = wd[7]; end
    if (upd_m || upd_c) e_lock = 1;
    else if (ack) e_lock = 0;
  endtask

  task automatic step(input string tag, input logic tv, input logic [1:0] k,
                      input logic [CNT_W-1:0] n, input logic crc, input logic tg,
                      input logic wr, input logic [1:0] sel, input logic [7:0] wd,
                      input logic ack, input logic br);
    @(negedge clk_i);
    tok_valid_i = tv; tok_kind_i = k; rx_count_i = n; rx_crc_ok_i = crc; rx_toggle_i = tg;
    fw_wr_i = wr; fw_sel_i = sel; fw_wdata_i = wd; fw_ack_i = ack; bus_reset_i = br;
    model(tv, k, n, crc, tg, wr, sel, wd, ack, br);
    @(posedge clk_i);
    #1;
    compare(tag);
  endtask

  task automatic tok(input string tag, input logic [1:0] k, input logic [CNT_W-1:0] n,
                     input logic crc, input logic tg);
    step(tag, 1, k, n, crc, tg, 0, 0, 0, 0, 0);
  endtask

  task automatic fw(input string tag, input logic [1:0] sel, input logic [7:0] wd);
    step(tag, 0, 0, 0, 0, 0, 1, sel, wd, 0, 0);
  endtask

  task automatic ack(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] codes [8];
    codes = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0110, 4'b1000, 4'b1011, 4'b1111};
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    #1;
    compare("R11 reset state");
    rst_ni = 1'b1;

    tok("R1 setup while off", 0, 3, 1, 0);
    tok("R1 in while off", 1, 0, 1, 0);
    fw("R9 unlocked mode write", 0, 8'h01);
    tok("R2 nak in", 1, 0, 1, 0);
    tok("R2 nak out", 2, 4, 1, 1);
    fw("R9 mode 1000", 0, 8'h08);
    tok("R2 nak-out mode out", 2, 2, 1, 0);
    tok("R2 nak-out mode in", 1, 0, 1, 0);
    fw("R3 mode stall", 0, 8'h03);
    tok("R3 stall in", 1, 0, 1, 0);
    tok("R3 stall out", 2, 1, 1, 0);
    tok("R4 setup count 11 dropped", 0, 11, 1, 0);
    tok("R4 setup count 10 over stall", 0, 10, 1, 0);
    fw("R9 write while locked", 0, 8'h0B);
    ack("R9 ack clears lock");
    fw("R9 mode 1011", 0, 8'h0B);
    tok("R6 fresh out", 2, 5, 1, 1);
    tok("R6 repeated toggle out", 2, 7, 1, 1);
    tok("R8 bad crc out", 2, 3, 0, 0);
    tok("R6 status in", 1, 0, 1, 0);
    ack("R9 ack");
    fw("R9 mode 1111", 0, 8'h0F);
    tok("R7 data in", 1, 0, 1, 0);
    tok("R7 out with data", 2, 2, 1, 0);
    tok("R7 zero out", 2, 0, 1, 0);
    ack("R9 ack");
    fw("R5 mode 0010", 0, 8'h02);
    tok("R5 in during status out", 1, 0, 1, 0);
    tok("R5 out with data", 2, 1, 1, 0);
    tok("R5 zero out", 2, 0, 1, 0);
    ack("R9 ack");
    fw("R5 mode 0110", 0, 8'h06);
    tok("R5 out during status in", 2, 0, 1, 0);
    tok("R5 status in", 1, 0, 1, 0);
    tok("R4 setup bad crc", 0, 4, 0, 1);
    ack("R9 ack");
    fw("R9 count write", 1, 8'hC9);
    fw("R3 undefined code 0100", 0, 8'h04);
    tok("R3 undefined in", 1, 0, 1, 0);
    tok("R11 reserved token", 3, 0, 1, 0);
    step("R9 engine beats fw", 1, 0, 2, 1, 0, 1, 0, 8'h03, 1, 0);
    fw("R10 addr write under lock", 2, 8'h55);
    step("R10 bus reset beats write", 0, 0, 0, 0, 0, 1, 2, 8'h2A, 0, 1);
    fw("R10 addr write", 2, 8'h7F);
    step("R10 bus reset", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R11 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [1:0] sel = 2'($urandom % 4);
      logic [7:0] wd = 8'($urandom);
      if (sel == 0) wd[3:0] = codes[$urandom % 8];
      step("R11 random", ($urandom % 2) == 0, 2'($urandom % 4), CNT_W'($urandom),
           ($urandom % 8) != 0, 1'($urandom), ($urandom % 3) == 0, sel, wd,
           ($urandom % 3) == 0, ($urandom % 40) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule